// File: doc/BRIEF.md
# Bus Hold Arbitration Controller

This block hands a processor's external memory bus to another bus master. The other master raises an asynchronous hold request. The block resynchronizes that request onto the state clock. A bus cycle that is already running always finishes first, including every wait state and, for a word moved over an 8-bit bus, both byte transfers. Only then does the block raise the grant and float the processor's address, data and control drivers. When the request is withdrawn, the grant falls and the processor resumes driving the bus in the same state.

While the bus is granted away, the processor may keep running from internal resources. When it needs the external bus, the block raises a bus-request flag back to the other master. Two kinds of need count: a data access, or an external code fetch once the prefetch queue has run low. The flag stays up until the grant is withdrawn. While it is up, the stalled requester is signalled and interrupt service is blocked. A small bus-cycle sequencer stands in for the real bus controller, so that cycles of every length can be provoked.

Top module: `hold_arb`

## Requirements
- R1: After reset, hlda, breq, stall, irq_blk, dat_oe and cyc_act are 0, and adr_oe and ctl_oe are 1.
- R2: With default parameters, hold_in passes through two flops before it is recognized, so with an idle bus hlda rises on the third rising edge after hold_in changes. With SYNC_BYPASS=1 only one flop is used and hlda rises on the second edge.
- R3: With no bus cycle in progress, hlda rises on the first edge after hold is recognized.
- R4: A bus cycle in progress delays hlda. hlda rises on the edge after the later of two events: hold recognition, or the end of the cycle. A cycle lasts BASE_STATES states per transfer. A 16-bit access (acc_kind 0) or a byte on the 8-bit bus (acc_kind 1) started together with hold adds one state.
- R5: A word on the 8-bit bus (acc_kind 2) runs two back-to-back transfers, and hlda waits for both. Started together with hold, it adds three states.
- R6: Each wait state (acc_waits) lengthens every transfer of the cycle by one state, and so delays hlda by one state per wait per transfer.
- R7: No bus cycle starts while hold is recognized or hlda is high. A request pending at release starts on the edge after hlda falls.
- R8: After hold_in falls, hlda falls with the same synchronizer delay as on entry, and adr_oe and ctl_oe return to 1 in that same state.
- R9: While hlda is 1, adr_oe, dat_oe and ctl_oe are all 0. dat_oe is 1 during a write cycle while the bus is owned.
- R10: breq is 0 whenever hlda is 0. While hlda is 1, breq rises in the same state that a need appears, and it stays 1 until hlda falls.
- R11: An external code fetch (fetch_ext=1) counts as a need only when queue_lvl is at or below LOW_MARK (default 2).
- R12: stall is 1 while hlda is 1 and a need is present. irq_blk is 1 from the first need until hlda falls.
- R13: In idle mode (idle_mode=1), access requests start no bus cycle, and hold is granted with the idle-bus latency.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | State clock |
| rst_n | input | 1 | Synchronous active-low reset |
| hold_in | input | 1 | Asynchronous hold request from the other master |
| acc_req | input | 1 | Processor wants an external data access |
| acc_kind | input | 2 | 0 16-bit, 1 byte on 8-bit bus, 2 word on 8-bit bus, 3 as 0 |
| acc_wr | input | 1 | Access is a write |
| acc_waits | input | WAIT_W | Wait states per transfer |
| fetch_ext | input | 1 | Code runs from external memory |
| queue_lvl | input | QLVL_W | Bytes held in the prefetch queue |
| idle_mode | input | 1 | Processor is in idle mode |
| hlda | output | 1 | Hold acknowledge |
| breq | output | 1 | Processor needs the bus back |
| adr_oe | output | 1 | Address driver enable |
| dat_oe | output | 1 | Data driver enable |
| ctl_oe | output | 1 | Control strobe driver enable |
| cyc_act | output | 1 | A bus cycle is in progress |
| stall | output | 1 | Requester must wait |
| irq_blk | output | 1 | Interrupt service is blocked |

## Verification
Two events can land in the same state. The first is the grant, together with a need that appears the moment the grant is taken; this must raise breq in that state. The second is a release together with a still-pending access, which must start only after hlda has dropped. The bench provokes both by driving the need and the release around the edges at which hold is recognized. A second instance, built with the bypassed synchronizer, has its grant one state earlier, so the two instances disagree exactly where a same-state rule would fail. Each grant and release edge is checked against a cycle number that the bench computes from the cycle length and the synchronizer depth.

// File: rtl/hold_arb_pkg.sv
`timescale 1ns/1ps
// Shared types for the hold arbitration controller.
package hold_arb_pkg;

    // Kind of external access requested by the processor.
    typedef enum logic [1:0] {
        KIND_W16 = 2'd0,   // one transfer on the 16-bit bus
        KIND_B8  = 2'd1,   // one byte transfer on the 8-bit bus
        KIND_W8  = 2'd2,   // word on the 8-bit bus: two transfers
        KIND_RSV = 2'd3    // treated as KIND_W16
    } acc_kind_e;

    // Bus ownership state.
    typedef enum logic {
        GS_OWN  = 1'b0,
        GS_HELD = 1'b1
    } grant_st_e;

endpackage

// File: rtl/hold_sync.sv
`timescale 1ns/1ps
// Resynchronizes the asynchronous hold request onto the state clock.
// Assumes hold_async may change at any time. BYPASS=1 keeps a single flop,
// modelling a request that always meets setup to the sampling edge.
module hold_sync #(
    parameter bit BYPASS = 1'b0
) (
    input  logic clk,
    input  logic rst_n,
    input  logic hold_async,
    output logic hold_rec
);
    logic smp_q;

    // First stage: sample the raw request.
    always_ff @(posedge clk) begin
        if (!rst_n) smp_q <= 1'b0;
        else        smp_q <= hold_async;
    end

    generate
        if (BYPASS) begin : g_one
            assign hold_rec = smp_q;
        end else begin : g_two
            logic rec_q;
            // Second stage: settle the sampled value.
            always_ff @(posedge clk) begin
                if (!rst_n) rec_q <= 1'b0;
                else        rec_q <= smp_q;
            end
            assign hold_rec = rec_q;
        end
    endgenerate

endmodule

// File: rtl/bus_seq.sv
`timescale 1ns/1ps
// Bus-cycle sequencer stub. It runs one or two transfers per access. Each
// transfer lasts BASE_STATES plus the requested wait states. busy stays
// high for the whole access. Assumes go is only raised while busy is low.
module bus_seq
    import hold_arb_pkg::*;
#(
    parameter int BASE_STATES = 2,
    parameter int WAIT_W      = 3
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              go,
    input  acc_kind_e         kind,
    input  logic              wr,
    input  logic [WAIT_W-1:0] waits,
    output logic              busy,
    output logic              wr_act
);
    localparam int CNT_W = $clog2(BASE_STATES + (1 << WAIT_W)) + 1;

    logic              busy_q;
    logic              two_q;
    logic              wr_q;
    logic [CNT_W-1:0]  cnt_q;
    logic [WAIT_W-1:0] waits_q;
    logic [CNT_W-1:0]  span_new;
    logic [CNT_W-1:0]  span_rep;

    // Remaining-state count loaded at the start of each transfer.
    assign span_new = CNT_W'(BASE_STATES - 1) + CNT_W'(waits);
    assign span_rep = CNT_W'(BASE_STATES - 1) + CNT_W'(waits_q);

    // Transfer sequencing: start, count down, chain the second byte, finish.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            busy_q  <= 1'b0;
            two_q   <= 1'b0;
            wr_q    <= 1'b0;
            cnt_q   <= '0;
            waits_q <= '0;
        end else if (!busy_q) begin
            if (go) begin
                busy_q  <= 1'b1;
                cnt_q   <= span_new;
                two_q   <= (kind == KIND_W8);
                wr_q    <= wr;
                waits_q <= waits;
            end
        end else if (cnt_q != '0) begin
            cnt_q <= cnt_q - 1'b1;
        end else if (two_q) begin
            two_q <= 1'b0;
            cnt_q <= span_rep;
        end else begin
            busy_q <= 1'b0;
            wr_q   <= 1'b0;
        end
    end

    assign busy   = busy_q;
    assign wr_act = busy_q & wr_q;

    // The second byte of a word always follows the first without a gap.
    p_word8_chain_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (busy_q && cnt_q == '0 && two_q) |=> busy_q);

endmodule

// File: rtl/hold_grant.sv
`timescale 1ns/1ps
// Grant/release state machine plus the bus-request logic used while held.
// It grants only when hold is recognized and no bus cycle is running, and
// releases on the first state after recognition drops. breq, stall and
// irq_blk are qualified by the held state.
module hold_grant
    import hold_arb_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic hold_rec,
    input  logic bus_busy,
    input  logic need,
    output logic held,
    output logic breq,
    output logic stall,
    output logic irq_blk
);
    grant_st_e st_q;
    logic      need_q;
    logic      blk;

    // Ownership transitions.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q <= GS_OWN;
        end else begin
            case (st_q)
                GS_OWN:  if (hold_rec && !bus_busy) st_q <= GS_HELD;
                GS_HELD: if (!hold_rec)             st_q <= GS_OWN;
                default: st_q <= GS_OWN;
            endcase
        end
    end

    // Remember a need seen while held until ownership returns.
    always_ff @(posedge clk) begin
        if (!rst_n)               need_q <= 1'b0;
        else if (st_q != GS_HELD) need_q <= 1'b0;
        else if (need)            need_q <= 1'b1;
    end

    assign held    = (st_q == GS_HELD);
    assign blk     = held & (need_q | need);
    assign breq    = blk;
    assign irq_blk = blk;
    assign stall   = held & need;

    p_grant_after_cycle_r4: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(held) |-> $past(hold_rec && !bus_busy));

    p_release_next_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (held && !hold_rec) |=> !held);

    p_breq_sticky_r10: assert property (@(posedge clk) disable iff (!rst_n)
        (breq && hold_rec) |=> breq);

    p_breq_only_held_r10: assert property (@(posedge clk) disable iff (!rst_n)
        breq |-> held);

endmodule

// File: rtl/hold_arb.sv
`timescale 1ns/1ps
// Top of the bus hold arbitration controller. It joins the synchronizer,
// the bus-cycle sequencer and the grant machine. It blocks new bus cycles
// while hold is recognized or granted, and turns off every bus driver while
// the grant is out. Assumes the processor holds acc_req until a cycle starts.
module hold_arb
    import hold_arb_pkg::*;
#(
    parameter bit SYNC_BYPASS = 1'b0,
    parameter int BASE_STATES = 2,
    parameter int WAIT_W      = 3,
    parameter int QLVL_W      = 3,
    parameter int LOW_MARK    = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              hold_in,
    input  logic              acc_req,
    input  logic [1:0]        acc_kind,
    input  logic              acc_wr,
    input  logic [WAIT_W-1:0] acc_waits,
    input  logic              fetch_ext,
    input  logic [QLVL_W-1:0] queue_lvl,
    input  logic              idle_mode,
    output logic              hlda,
    output logic              breq,
    output logic              adr_oe,
    output logic              dat_oe,
    output logic              ctl_oe,
    output logic              cyc_act,
    output logic              stall,
    output logic              irq_blk
);
    localparam logic [QLVL_W-1:0] LOW_LVL = QLVL_W'(LOW_MARK);

    logic hold_rec;
    logic busy;
    logic wr_act;
    logic held;
    logic go;
    logic need;

    hold_sync #(.BYPASS(SYNC_BYPASS)) u_sync (
        .clk        (clk),
        .rst_n      (rst_n),
        .hold_async (hold_in),
        .hold_rec   (hold_rec)
    );

    // A cycle may start only with the bus owned and no hold pending.
    assign go = acc_req & ~idle_mode & ~hold_rec & ~held & ~busy;

    // A need is a data access or a fetch with the queue running low.
    assign need = acc_req | (fetch_ext & (queue_lvl <= LOW_LVL));

    bus_seq #(.BASE_STATES(BASE_STATES), .WAIT_W(WAIT_W)) u_seq (
        .clk    (clk),
        .rst_n  (rst_n),
        .go     (go),
        .kind   (acc_kind_e'(acc_kind)),
        .wr     (acc_wr),
        .waits  (acc_waits),
        .busy   (busy),
        .wr_act (wr_act)
    );

    hold_grant u_grant (
        .clk      (clk),
        .rst_n    (rst_n),
        .hold_rec (hold_rec),
        .bus_busy (busy),
        .need     (need),
        .held     (held),
        .breq     (breq),
        .stall    (stall),
        .irq_blk  (irq_blk)
    );

    assign hlda    = held;
    assign adr_oe  = ~held;
    assign ctl_oe  = ~held;
    assign dat_oe  = ~held & wr_act;
    assign cyc_act = busy;

    p_oe_off_held_r9: assert property (@(posedge clk) disable iff (!rst_n)
        hlda |-> (!adr_oe && !dat_oe && !ctl_oe));

    p_no_start_blocked_r7: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(cyc_act) |-> $past(!hold_rec && !hlda));

    p_idle_no_start_r13: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(cyc_act) |-> $past(!idle_mode));

endmodule

// File: tb/sim_hold_arb.sv
`timescale 1ns/1ps
// Scoreboard bench: drivers queue the expected hlda edges, monitors compare.
module sim_hold_arb;
    localparam int BASE = 2;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       hold_in = 1'b0;
    logic       acc_req = 1'b0;
    logic [1:0] acc_kind = 2'd0;
    logic       acc_wr = 1'b0;
    logic [2:0] acc_waits = 3'd0;
    logic       fetch_ext = 1'b0;
    logic [2:0] queue_lvl = 3'd7;
    logic       idle_mode = 1'b0;

    logic hlda, breq, adr_oe, dat_oe, ctl_oe, cyc_act, stall, irq_blk;
    logic hlda1, breq1, adr_oe1, dat_oe1, ctl_oe1, cyc_act1, stall1, irq_blk1;

    int  cyc = 0;
    int  n_chk = 0;
    int  n_fail = 0;
    bit  done = 1'b0;

    typedef struct { bit lvl; int at; string tag; } ev_t;
    ev_t sb0[$];
    ev_t sb1[$];

    always #10 clk = ~clk;   // 50 MHz
    always @(posedge clk) cyc <= cyc + 1;

    hold_arb u0 (
        .clk(clk), .rst_n(rst_n), .hold_in(hold_in), .acc_req(acc_req),
        .acc_kind(acc_kind), .acc_wr(acc_wr), .acc_waits(acc_waits),
        .fetch_ext(fetch_ext), .queue_lvl(queue_lvl), .idle_mode(idle_mode),
        .hlda(hlda), .breq(breq), .adr_oe(adr_oe), .dat_oe(dat_oe),
        .ctl_oe(ctl_oe), .cyc_act(cyc_act), .stall(stall), .irq_blk(irq_blk)
    );

    hold_arb #(.SYNC_BYPASS(1'b1)) u1 (
        .clk(clk), .rst_n(rst_n), .hold_in(hold_in), .acc_req(acc_req),
        .acc_kind(acc_kind), .acc_wr(acc_wr), .acc_waits(acc_waits),
        .fetch_ext(fetch_ext), .queue_lvl(queue_lvl), .idle_mode(idle_mode),
        .hlda(hlda1), .breq(breq1), .adr_oe(adr_oe1), .dat_oe(dat_oe1),
        .ctl_oe(ctl_oe1), .cyc_act(cyc_act1), .stall(stall1), .irq_blk(irq_blk1)
    );

    task automatic chk(input bit ok, input string tag, input int act, input int exp);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s: actual %0d expected %0d (cycle %0d)", tag, act, exp, cyc);
        end
    endtask

    task automatic summary();
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    endtask

    function automatic int imax(input int a, input int b);
        return (a > b) ? a : b;
    endfunction

    // Monitors: compare every hlda edge with the queued expectation.
    bit  prev0 = 1'b0;
    bit  prev1 = 1'b0;
    ev_t e0;
    ev_t e1;
    always @(negedge clk) begin
        if (rst_n) begin
            if (hlda !== prev0) begin
                if (sb0.size() == 0) chk(1'b0, "R2 unexpected hlda edge u0", int'(hlda), int'(prev0));
                else begin
                    e0 = sb0.pop_front();
                    chk(hlda == e0.lvl && cyc == e0.at, e0.tag, cyc, e0.at);
                end
            end
            prev0 = hlda;
            if (hlda1 !== prev1) begin
                if (sb1.size() == 0) chk(1'b0, "R2 unexpected hlda edge u1", int'(hlda1), int'(prev1));
                else begin
                    e1 = sb1.pop_front();
                    chk(hlda1 == e1.lvl && cyc == e1.at, {"R2 bypass ", e1.tag}, cyc, e1.at);
                end
            end
            prev1 = hlda1;
            if (hlda) chk(!(adr_oe | dat_oe | ctl_oe), "R9 drivers off while held",
                          int'({adr_oe, dat_oe, ctl_oe}), 0);
        end
    end

    // One grant/release round; expected edges come from the cycle lengths.
    task automatic grant_run(input int kind, input int waits, input bit wr,
                             input bit with_cyc, input bit idle, input string tag);
        int k, n, eb, g0, g1, r;
        @(negedge clk);
        k = cyc;
        hold_in   = 1'b1;
        idle_mode = idle;
        if (with_cyc || idle) begin
            acc_req   = 1'b1;
            acc_kind  = 2'(kind);
            acc_waits = 3'(waits);
            acc_wr    = wr;
        end
        n  = (kind == 2) ? 2 : 1;
        eb = with_cyc ? k + 1 + n * (BASE + waits) : 0;
        g0 = imax(k + 2, eb) + 1;
        g1 = imax(k + 1, eb) + 1;
        sb0.push_back('{1'b1, g0, tag});
        sb1.push_back('{1'b1, g1, tag});
        @(negedge clk);
        acc_req = 1'b0;
        acc_wr  = 1'b0;
        if (wr) chk(dat_oe == 1'b1, "R9 dat_oe on write cycle", int'(dat_oe), 1);
        if (idle) chk(cyc_act == 1'b0 && cyc_act1 == 1'b0, "R13 no cycle in idle mode", int'(cyc_act), 0);
        while (cyc < g0 + 1) @(negedge clk);
        chk(hlda == 1'b1, tag, int'(hlda), 1);
        idle_mode = 1'b0;
        r = cyc;
        hold_in = 1'b0;
        sb0.push_back('{1'b0, r + 3, "R8 release u0"});
        sb1.push_back('{1'b0, r + 2, "R8 release"});
        while (cyc < r + 3) @(negedge clk);
        chk(adr_oe == 1'b1 && ctl_oe == 1'b1, "R8 drivers back with hlda low", int'(adr_oe), 1);
        repeat (3) @(negedge clk);
    endtask

    // Need appearing at the grant, stickiness, and a request pending at release.
    task automatic breq_run();
        int k, r;
        @(negedge clk);
        k = cyc;
        hold_in = 1'b1;
        sb0.push_back('{1'b1, k + 3, "R3 grant before breq"});
        sb1.push_back('{1'b1, k + 2, "R3 grant before breq"});
        while (cyc < k + 2) @(negedge clk);
        acc_req = 1'b1; acc_kind = 2'd0; acc_waits = 3'd0;
        #2;
        chk(breq == 1'b0, "R10 breq low before hlda", int'(breq), 0);
        chk(breq1 == 1'b1, "R10 breq with need while held", int'(breq1), 1);
        chk(stall1 == 1'b1, "R12 stall while held with need", int'(stall1), 1);
        @(negedge clk);
        chk(hlda == 1'b1 && breq == 1'b1, "R10 breq in same state as hlda", int'(breq), 1);
        chk(cyc_act == 1'b0, "R7 no cycle while held", int'(cyc_act), 0);
        @(negedge clk);
        acc_req = 1'b0;
        #2;
        chk(breq == 1'b1, "R10 breq sticky after need drops", int'(breq), 1);
        chk(irq_blk == 1'b1, "R12 irq_blk held", int'(irq_blk), 1);
        chk(stall == 1'b0, "R12 stall follows need", int'(stall), 0);
        repeat (3) @(negedge clk);
        chk(breq == 1'b1 && irq_blk == 1'b1, "R10 breq still high", int'(breq), 1);
        r = cyc;
        hold_in = 1'b0;
        acc_req = 1'b1;
        sb0.push_back('{1'b0, r + 3, "R8 release with pending access"});
        sb1.push_back('{1'b0, r + 2, "R8 release with pending access"});
        @(negedge clk);
        @(negedge clk);
        chk(breq == 1'b1, "R10 breq until hlda falls", int'(breq), 1);
        chk(cyc_act1 == 1'b0, "R7 no start in release state", int'(cyc_act1), 0);
        @(negedge clk);
        chk(breq == 1'b0 && irq_blk == 1'b0, "R10 breq drops with hlda", int'(breq), 0);
        chk(cyc_act == 1'b0, "R7 pending start waits for hlda low", int'(cyc_act), 0);
        chk(cyc_act1 == 1'b1, "R7 pending access starts after release", int'(cyc_act1), 1);
        @(negedge clk);
        chk(cyc_act == 1'b1, "R7 pending access starts after release u0", int'(cyc_act), 1);
        acc_req = 1'b0;
        repeat (6) @(negedge clk);
    endtask

    // Code fetch need depends on the queue level.
    task automatic fetch_run();
        int k;
        @(negedge clk);
        k = cyc;
        hold_in = 1'b1;
        fetch_ext = 1'b1;
        queue_lvl = 3'd3;
        sb0.push_back('{1'b1, k + 3, "R3 grant for fetch"});
        sb1.push_back('{1'b1, k + 2, "R3 grant for fetch"});
        while (cyc < k + 4) @(negedge clk);
        chk(breq == 1'b0, "R11 queue above mark is no need", int'(breq), 0);
        queue_lvl = 3'd2;
        #2;
        chk(breq == 1'b1, "R11 queue at mark raises breq", int'(breq), 1);
        @(negedge clk);
        queue_lvl = 3'd5;
        #2;
        chk(breq == 1'b1, "R10 breq kept after refill", int'(breq), 1);
        @(negedge clk);
        k = cyc;
        hold_in = 1'b0;
        fetch_ext = 1'b0;
        sb0.push_back('{1'b0, k + 3, "R8 release after fetch"});
        sb1.push_back('{1'b0, k + 2, "R8 release after fetch"});
        repeat (5) @(negedge clk);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        chk(hlda == 0 && breq == 0 && stall == 0 && irq_blk == 0, "R1 reset outputs low", int'(hlda), 0);
        chk(adr_oe == 1 && ctl_oe == 1 && dat_oe == 0 && cyc_act == 0, "R1 reset drivers", int'(adr_oe), 1);
        grant_run(0, 0, 1'b0, 1'b0, 1'b0, "R3 idle bus grant");
        grant_run(0, 0, 1'b0, 1'b1, 1'b0, "R4 16-bit cycle grant");
        grant_run(1, 0, 1'b0, 1'b1, 1'b0, "R4 byte cycle grant");
        grant_run(2, 0, 1'b0, 1'b1, 1'b0, "R5 word on 8-bit bus grant");
        grant_run(0, 3, 1'b1, 1'b1, 1'b0, "R6 wait states delay grant");
        grant_run(2, 2, 1'b0, 1'b1, 1'b0, "R6 waits on both byte transfers");
        grant_run(0, 0, 1'b0, 1'b0, 1'b1, "R13 idle mode grant");
        breq_run();
        fetch_run();
        chk(sb0.size() == 0 && sb1.size() == 0, "R2 all expected edges seen", sb0.size(), 0);
        done = 1'b1;
        summary();
    end

    // Watchdog: a hung run counts as a failure.
    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            chk(1'b0, "R1 watchdog expired", cyc, 0);
            summary();
        end
    end

endmodule